// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The host hands over one byte access at a time on a valid/ready port. The controller then plays out the RAM's pin sequence from registered outputs, in whole clock cycles. The pins are a 17-bit address, an active-low select paired with an active-high select, an active-low write strobe and an active-low output enable. The data bus is split into an output byte, a drive enable and an input byte, so the pad ring can build the tri-state buffer.

Every RAM timing figure is given to the block in picoseconds, together with the clock period. The block turns each figure into a cycle count by dividing and rounding up, with a minimum of one cycle. A read keeps output enable low for the access window and samples the bus on the last edge of that window. It then releases the bus and waits out the RAM's output turn-off time, so the next transfer cannot collide with the RAM's drivers.

Writes come in two variants, chosen by a parameter. In the default variant, output enable stays high and the write pulse only has to meet its minimum width. In the other variant, output enable stays low throughout the write. The pulse is then stretched to cover the RAM's turn-off time plus the data setup time, and the controller drives the bus only in the tail of the pulse.

Top module: `asyncram_ctrl`

## Requirements
- R1: While reset is held, the high-active select is low, the low-active select is high, write strobe and output enable are high, the drive enable is low and ready is high.
- R2: The two selects always change together, so the RAM is either selected (low-active select 0, high-active select 1) or deselected (1, 0). Whenever ready is high the RAM is deselected.
- R3: Let AA = ceil(max(access, output-enable access) / clock). In a read, the RAM is selected with output enable low, write strobe high and the bus undriven for AA cycles. The byte on the input bus at the last of those edges appears on rdData, with rdValid high, in cycle AA+1 after the accepting edge.
- R4: The controller never drives the bus in a cycle where the pins let the RAM drive it (selected, output enable low, write strobe high). It also drives only after at least OFF = ceil(turn-off / clock) cycles in which the RAM could not drive.
- R5: With the output-enable-low parameter at 0, a write selects the RAM with output enable high. It drives the data for one cycle before the write strobe falls, holds the strobe low for exactly ceil(pulse width / clock) cycles, and keeps the data driven through the edge where the strobe rises.
- R6: With the output-enable-low parameter at 1, output enable stays low for every cycle the write strobe is low. The strobe is low for P = max(ceil(pulse width / clock), OFF + ceil(data setup / clock)) cycles, and the data is driven only in its last P - OFF cycles.
- R7: A request is taken on a clock edge where valid and ready are both high. Ready then stays low until the sequence ends: AA+OFF cycles for a read; P+2 cycles for a write in the default variant; P+OFF+1 cycles for a write in the output-enable-low variant. Holding valid high through this time starts no second access.
- R8: The write strobe is low only while the RAM is selected, and the address does not change while the RAM stays selected. The address seen at the rising strobe is the one the host gave.
- R9: rdValid is a one-cycle pulse, given exactly once per read and never for a write.
- R10: A byte written to an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostValid | input | 1 | Host request present |
| hostReady | output | 1 | Controller idle and able to accept |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostAddr | input | 17 | Byte address |
| hostWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-cycle strobe marking rdData |
| rdData | output | 8 | Captured read byte |
| memAddr | output | 17 | RAM address pins |
| memCe1N | output | 1 | Select, active low |
| memCe2 | output | 1 | Select, active high |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memDataOut | output | 8 | Byte to drive onto the RAM bus |
| memDataOe | output | 1 | Drive enable for memDataOut |
| memDataIn | input | 8 | Byte read from the RAM bus |

## Verification
The bus-turn check models the RAM as driving in every cycle where its pins call for a read. It therefore assumes the real part floats no later than the turn-off figure given in the parameters; the bench RAM model is built to that assumption and returns a fixed junk byte whenever it is not driving. The handshake checks assume the host raises valid only between edges and keeps the request fields steady until it is accepted. The bench tasks meet this by driving the inputs only on the falling clock edge and only once ready is seen.

// File: rtl/asyncram_pkg.sv
package asyncram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // latch host request
    logic capture;  // sample read bus at this edge
    logic selOn;    // select RAM next cycle
    logic oeOn;     // output enable low next cycle
    logic weOn;     // write strobe low next cycle
    logic drvOn;    // drive bus next cycle
  } seqStrobes_t;

  // picoseconds to whole clock cycles, rounded up, minimum one
  function automatic int psToCycles(int ps, int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/asyncram_seq.sv
module asyncram_seq
  import asyncram_pkg::*;
#(
  parameter int AA_CYC       = 1,
  parameter int PULSE_CYC    = 1,
  parameter int OFF_CYC      = 1,
  parameter bit OE_LOW_WRITE = 1'b0,
  parameter int CNT_W        = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  output logic        hostReady,
  output seqStrobes_t strobes
);

  seqState_t state, nextState;
  logic [CNT_W-1:0] elapsed, nextElapsed;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (hostValid) nextState = hostWrite ? ST_WSET : ST_RD;
      ST_RD:     if (elapsed == CNT_W'(AA_CYC - 1)) nextState = ST_TURN;
      ST_WSET:   nextState = ST_WPULSE;
      ST_WPULSE: if (elapsed == CNT_W'(PULSE_CYC - 1))
                   nextState = OE_LOW_WRITE ? ST_TURN : ST_WHOLD;
      ST_WHOLD:  nextState = ST_IDLE;
      ST_TURN:   if (elapsed == CNT_W'(OFF_CYC - 1)) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
    nextElapsed = (nextState != state) ? '0 : elapsed + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elapsed <= '0;
    end else begin
      state   <= nextState;
      elapsed <= nextElapsed;
    end
  end

  always_comb begin
    hostReady       = (state == ST_IDLE);
    strobes.load    = (state == ST_IDLE) && hostValid;
    strobes.capture = (state == ST_RD) && (elapsed == CNT_W'(AA_CYC - 1));
    strobes.selOn   = nextState inside {ST_RD, ST_WSET, ST_WPULSE, ST_WHOLD};
    strobes.oeOn    = (nextState == ST_RD) ||
                      (OE_LOW_WRITE && (nextState inside {ST_WSET, ST_WPULSE}));
    strobes.weOn    = (nextState == ST_WPULSE);
    strobes.drvOn   = (nextState == ST_WHOLD) ||
                      (!OE_LOW_WRITE && nextState == ST_WSET) ||
                      (nextState == ST_WPULSE &&
                       (!OE_LOW_WRITE || nextElapsed >= CNT_W'(OFF_CYC)));
  end

endmodule

// File: rtl/asyncram_dp.sv
module asyncram_dp
  import asyncram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr    <= '0;
      memDataOut <= '0;
      memCe1N    <= 1'b1;
      memCe2     <= 1'b0;
      memWeN     <= 1'b1;
      memOeN     <= 1'b1;
      memDataOe  <= 1'b0;
      rdData     <= '0;
      rdValid    <= 1'b0;
    end else begin
      if (strobes.load) begin
        memAddr    <= hostAddr;
        memDataOut <= hostWdata;
      end
      memCe1N   <= !strobes.selOn;
      memCe2    <= strobes.selOn;
      memWeN    <= !strobes.weOn;
      memOeN    <= !strobes.oeOn;
      memDataOe <= strobes.drvOn;
      rdValid   <= strobes.capture;
      if (strobes.capture) rdData <= memDataIn;
    end
  end

endmodule

// File: rtl/asyncram_ctrl.sv
module asyncram_ctrl
  import asyncram_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CLK_PS       = 10000,
  parameter int T_AA_PS      = 10000,
  parameter int T_AOE_PS     = 6000,
  parameter int T_WP_PS      = 8000,
  parameter int T_OFF_PS     = 5000,
  parameter int T_DW_PS      = 6000,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);

  localparam int AA_RAW    = psToCycles(T_AA_PS, CLK_PS);
  localparam int AOE_CYC   = psToCycles(T_AOE_PS, CLK_PS);
  localparam int AA_CYC    = (AA_RAW > AOE_CYC) ? AA_RAW : AOE_CYC;
  localparam int WP_CYC    = psToCycles(T_WP_PS, CLK_PS);
  localparam int OFF_CYC   = psToCycles(T_OFF_PS, CLK_PS);
  localparam int DW_CYC    = psToCycles(T_DW_PS, CLK_PS);
  localparam int STRETCH   = OFF_CYC + DW_CYC;
  localparam int PULSE_CYC = (OE_LOW_WRITE && STRETCH > WP_CYC) ? STRETCH : WP_CYC;
  localparam int MAX_A     = (AA_CYC > PULSE_CYC) ? AA_CYC : PULSE_CYC;
  localparam int MAX_CYC   = (MAX_A > OFF_CYC) ? MAX_A : OFF_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqStrobes_t strobes;

  asyncram_seq #(
    .AA_CYC(AA_CYC), .PULSE_CYC(PULSE_CYC), .OFF_CYC(OFF_CYC),
    .OE_LOW_WRITE(OE_LOW_WRITE), .CNT_W(CNT_W)
  ) uSeq (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostReady(hostReady), .strobes(strobes)
  );

  asyncram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .memDataIn(memDataIn), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .rdData(rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/asyncram_chk.sv
module asyncram_chk
  import asyncram_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int CLK_PS       = 10000,
  parameter int T_OFF_PS     = 5000,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic              hostReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDataOe
);

  localparam logic [7:0] OFF_LIM = 8'(psToCycles(T_OFF_PS, CLK_PS));

  logic selected, ramDrive;
  logic [7:0] quietCnt;

  assign selected = !memCe1N && memCe2;
  assign ramDrive = selected && !memOeN && memWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          quietCnt <= 8'hFF;
    else if (ramDrive)  quietCnt <= 8'h00;
    else if (quietCnt != 8'hFF) quietCnt <= quietCnt + 8'h01;
  end

  // R2
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (memCe1N && !memCe2));

  // R8
  we_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> selected);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selected && $past(selected)) |-> $stable(memAddr));

  // R4
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (!ramDrive && quietCnt >= OFF_LIM));

  // R9
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> !hostReady);

  generate
    if (OE_LOW_WRITE) begin : gOeLow
      // R6
      oe_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        !memWeN |-> !memOeN);
    end else begin : gOeHigh
      // R5
      oe_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        !memWeN |-> memOeN);
    end
  endgenerate

endmodule

bind asyncram_ctrl asyncram_chk #(
  .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_OFF_PS(T_OFF_PS),
  .OE_LOW_WRITE(OE_LOW_WRITE)
) uChk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .rdValid(rdValid), .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
  .memWeN(memWeN), .memOeN(memOeN), .memDataOe(memDataOe)
);

// File: tb/sim_asyncram_ctrl.sv
`timescale 1ns/1ps
module sim_asyncram_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        hostValid [2];
  logic        hostReady [2];
  logic        hostWrite [2];
  logic [16:0] hostAddr  [2];
  logic [7:0]  hostWdata [2];
  logic        rdValid   [2];
  logic [7:0]  rdData    [2];
  logic [16:0] memAddr   [2];
  logic        memCe1N   [2];
  logic        memCe2    [2];
  logic        memWeN    [2];
  logic        memOeN    [2];
  logic [7:0]  memDataOut[2];
  logic        memDataOe [2];
  logic [7:0]  memDataIn [2];

  // u0: output enable high during writes; u1: output enable held low
  asyncram_ctrl #(.T_AA_PS(20000), .T_OFF_PS(15000), .T_WP_PS(8000),
                  .OE_LOW_WRITE(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .hostValid(hostValid[0]), .hostReady(hostReady[0]),
    .hostWrite(hostWrite[0]), .hostAddr(hostAddr[0]), .hostWdata(hostWdata[0]),
    .rdValid(rdValid[0]), .rdData(rdData[0]), .memAddr(memAddr[0]),
    .memCe1N(memCe1N[0]), .memCe2(memCe2[0]), .memWeN(memWeN[0]),
    .memOeN(memOeN[0]), .memDataOut(memDataOut[0]), .memDataOe(memDataOe[0]),
    .memDataIn(memDataIn[0]));

  asyncram_ctrl #(.T_OFF_PS(15000), .T_DW_PS(12000), .T_WP_PS(8000),
                  .OE_LOW_WRITE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .hostValid(hostValid[1]), .hostReady(hostReady[1]),
    .hostWrite(hostWrite[1]), .hostAddr(hostAddr[1]), .hostWdata(hostWdata[1]),
    .rdValid(rdValid[1]), .rdData(rdData[1]), .memAddr(memAddr[1]),
    .memCe1N(memCe1N[1]), .memCe2(memCe2[1]), .memWeN(memWeN[1]),
    .memOeN(memOeN[1]), .memDataOut(memDataOut[1]), .memDataOe(memDataOe[1]),
    .memDataIn(memDataIn[1]));

  function automatic int cyc(int ps);
    int c;
    c = (ps + 9999) / 10000;
    return (c < 1) ? 1 : c;
  endfunction

  int expAa [2], expOff [2], expPulse [2], expDrv [2], expWrReady [2];
  initial begin
    expAa[0] = (cyc(20000) > cyc(6000)) ? cyc(20000) : cyc(6000);
    expAa[1] = (cyc(10000) > cyc(6000)) ? cyc(10000) : cyc(6000);
    expOff[0] = cyc(15000);
    expOff[1] = cyc(15000);
    expPulse[0] = cyc(8000);
    expPulse[1] = (cyc(8000) > expOff[1] + cyc(12000)) ? cyc(8000) : expOff[1] + cyc(12000);
    expDrv[0] = expPulse[0] + 1;
    expDrv[1] = expPulse[1] - expOff[1];
    expWrReady[0] = expPulse[0] + 3;
    expWrReady[1] = expPulse[1] + expOff[1] + 2;
  end

  // RAM models
  logic [7:0] mem [2][256];
  logic [7:0] expMem [2][256];
  int weLow [2], drvRun [2], sinceRam [2], lastPulse [2], lastDrvRun [2];
  int wrEvents [2], contention [2], oeBad [2];
  logic [16:0] lastWrAddr [2];
  logic [7:0]  lastData [2];
  logic        prevWeN [2];

  for (genvar g = 0; g < 2; g++) begin : gRam
    assign memDataIn[g] = (!memCe1N[g] && memCe2[g] && !memOeN[g] && memWeN[g])
                          ? mem[g][memAddr[g][7:0]] : 8'hEE;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 256; i++) begin
        mem[k][i] = 8'(i * 7 + 3);
        expMem[k][i] = 8'(i * 7 + 3);
      end
      weLow[k] = 0; drvRun[k] = 0; sinceRam[k] = 1000; wrEvents[k] = 0;
      contention[k] = 0; oeBad[k] = 0; prevWeN[k] = 1'b1;
      lastPulse[k] = 0; lastDrvRun[k] = 0; lastWrAddr[k] = '0; lastData[k] = '0;
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      logic sel, drive;
      sel = !memCe1N[k] && memCe2[k];
      drive = sel && !memOeN[k] && memWeN[k];
      if (rstN) begin
        if (memWeN[k] && !prevWeN[k]) begin
          mem[k][memAddr[k][7:0]] = lastData[k];
          lastWrAddr[k] = memAddr[k];
          lastPulse[k] = weLow[k];
          lastDrvRun[k] = drvRun[k];
          weLow[k] = 0;
          wrEvents[k]++;
        end
        if (memDataOe[k] && (drive || sinceRam[k] < expOff[k])) contention[k]++;
        if (!memWeN[k]) begin
          weLow[k]++;
          if (memDataOe[k]) lastData[k] = memDataOut[k];
          if ((k == 0) ? !memOeN[k] : memOeN[k]) oeBad[k]++;
        end
        drvRun[k] = memDataOe[k] ? drvRun[k] + 1 : 0;
        sinceRam[k] = drive ? 0 : sinceRam[k] + 1;
        prevWeN[k] = memWeN[k];
      end
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitReady(int k);
    @(negedge clk);
    while (!hostReady[k]) @(negedge clk);
  endtask

  task automatic checkIdle(int k);
    chk(memCe1N[k] && !memCe2[k], "R2", "deselected when idle",
        {memCe1N[k], memCe2[k]}, 2);
  endtask

  task automatic doWrite(int k, logic [16:0] a, logic [7:0] d, bit holdValid);
    int n, ev0;
    waitReady(k);
    ev0 = wrEvents[k];
    hostValid[k] = 1'b1; hostWrite[k] = 1'b1; hostAddr[k] = a; hostWdata[k] = d;
    @(negedge clk);
    if (!holdValid) hostValid[k] = 1'b0;
    n = 1;
    while (!hostReady[k] && n < 60) begin @(negedge clk); n++; end
    hostValid[k] = 1'b0;
    chk(n == expWrReady[k], "R7", "write busy cycles", n, expWrReady[k]);
    chk(wrEvents[k] == ev0 + 1, "R7", "write strobes per request", wrEvents[k] - ev0, 1);
    chk(lastPulse[k] == expPulse[k], (k == 0) ? "R5" : "R6", "write pulse cycles",
        lastPulse[k], expPulse[k]);
    chk(lastDrvRun[k] == expDrv[k], (k == 0) ? "R5" : "R6", "driven cycles before rise",
        lastDrvRun[k], expDrv[k]);
    chk(lastWrAddr[k] == a, "R8", "address at strobe rise", int'(lastWrAddr[k]), int'(a));
    chk(mem[k][a[7:0]] == d, "R10", "byte stored", mem[k][a[7:0]], d);
    expMem[k][a[7:0]] = d;
    checkIdle(k);
  endtask

  task automatic doRead(int k, logic [16:0] a);
    int n, rvAt, rvCnt, bad;
    logic [7:0] got;
    waitReady(k);
    hostValid[k] = 1'b1; hostWrite[k] = 1'b0; hostAddr[k] = a; hostWdata[k] = 8'h5A;
    @(negedge clk);
    hostValid[k] = 1'b0;
    n = 1; rvAt = 0; rvCnt = 0; bad = 0; got = '0;
    while (!hostReady[k] && n < 60) begin
      if (rdValid[k]) begin rvAt = n; rvCnt++; got = rdData[k]; end
      if (!memCe1N[k] && memCe2[k] && (memOeN[k] || !memWeN[k] || memDataOe[k])) bad++;
      @(negedge clk); n++;
    end
    if (rdValid[k]) begin rvAt = n; rvCnt++; got = rdData[k]; end
    chk(bad == 0, "R3", "read pin levels", bad, 0);
    chk(rvAt == expAa[k] + 1, "R3", "rdValid cycle", rvAt, expAa[k] + 1);
    chk(rvCnt == 1, "R9", "rdValid pulses", rvCnt, 1);
    chk(got == expMem[k][a[7:0]], "R10", "read byte", got, expMem[k][a[7:0]]);
    chk(n == expAa[k] + expOff[k] + 1, "R7", "read ready cycle", n,
        expAa[k] + expOff[k] + 1);
  endtask

  task automatic finishSim();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R7", "watchdog expired", cycles, 150000);
      finishSim();
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      hostValid[k] = 1'b0; hostWrite[k] = 1'b0; hostAddr[k] = '0; hostWdata[k] = '0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      // R1 reset state
      chk(memCe1N[k] && !memCe2[k], "R1", "selects in reset", {memCe1N[k], memCe2[k]}, 2);
      chk(memWeN[k] && memOeN[k], "R1", "strobes in reset", {memWeN[k], memOeN[k]}, 3);
      chk(!memDataOe[k] && hostReady[k], "R1", "bus and ready in reset",
          {memDataOe[k], hostReady[k]}, 1);
    end
    rstN = 1'b1;

    for (int k = 0; k < 2; k++) begin
      // R3 reads of the preset pattern with walking address bits
      for (int b = 0; b < 17; b++) doRead(k, 17'(1) << b);
      // R10 sweep every byte value through every low address
      for (int i = 0; i < 256; i++)
        doWrite(k, {9'(i * 37), 8'(i)}, 8'(i * 13 + 5), 1'b0);
      for (int i = 0; i < 256; i++) doRead(k, {9'(i * 11), 8'(i)});
      // R8 walking-one write addresses, read straight back (R4 turnaround)
      for (int b = 0; b < 17; b++) begin
        doWrite(k, 17'(1) << b, 8'(~b), 1'b0);
        doRead(k, 17'(1) << b);
      end
      // R7 valid held high for the whole write
      doWrite(k, 17'h1ABCD, 8'hC3, 1'b1);
      doRead(k, 17'h1ABCD);
      chk(contention[k] == 0, "R4", "bus contention cycles", contention[k], 0);
      chk(oeBad[k] == 0, (k == 0) ? "R5" : "R6", "output enable during strobe",
          oeBad[k], 0);
    end
    finishSim();
  end

endmodule